// File: doc/BRIEF.md
# Pause flow control resolver

This block settles the pause flow-control mode of an Ethernet MAC once auto-negotiation has finished. It combines the two pause capability bits advertised by the local station, the two advertised by the link partner, the mode the user asked for and the negotiated duplex. From these it produces a two-bit resolved mode, the transmit and receive flow-control enables, and the two receive FIFO threshold words. The low threshold word carries an XON-enable flag in its top bit.

Resolution happens only on a single-cycle evaluation strobe. The inputs are sampled on the clock edge that sees the strobe, and the registered result appears in the next cycle together with a one-cycle valid pulse. A small state machine records what that evaluation did:

- `ST_IDLE`: no result this cycle.
- `ST_APPLIED`: a new result was loaded.
- `ST_HELD`: auto-negotiation was disabled, so the previous result was kept.
- `ST_FAULT`: the requested mode was illegal, so the previous result was kept and an error was flagged.

Every state moves to `ST_IDLE` when no strobe is present. When a strobe is present, every state moves to `ST_HELD`, `ST_FAULT` or `ST_APPLIED`, checked in that priority order.

Top module: `pause_fc_resolver`

## Requirements
- R1: After reset, `res_mode`, `tx_fc_en`, `rx_fc_en`, `lo_thresh`, `hi_thresh`, `res_valid` and `cfg_err` are all zero.
- R2: Mode encoding is 0 none, 1 receive pause only, 2 transmit pause only, 3 full. `req_mode` uses the same codes, and the value 4 means default and counts as full. When both local and partner pause bits are 1, the result is 3 if the request is 3 or 4, and 1 otherwise.
- R3: Local pause=0 and asym=1, with partner pause=1 and asym=1, resolves to 2.
- R4: Local pause=1 and asym=1, with partner pause=0 and asym=1, resolves to 1. Every combination not covered by R2 or R3 resolves to 0.
- R5: When `full_duplex` is 0 at the strobe, the resolved mode is 0 whatever the bits say.
- R6: `rx_fc_en` equals bit 0 of the resolved mode and `tx_fc_en` equals bit 1.
- R7: When the resolved mode includes transmit pause (mode 2 or 3), the low-order WATER_W bits of `lo_thresh` take `low_water` and `hi_thresh` takes `high_water`, both zero-extended. Otherwise both thresholds are 0.
- R8: Bit TH_W-1 of `lo_thresh` is 1 only when transmit pause is resolved and `xon_cfg` is 1 at the strobe.
- R9: A strobe with `an_enable`=0 gives `res_valid`=1 and `cfg_err`=0. It leaves mode, enables and thresholds unchanged.
- R10: A strobe with `an_enable`=1 and `req_mode` of 5, 6 or 7 gives `res_valid`=1 and `cfg_err`=1. It leaves mode, enables and thresholds unchanged.
- R11: `res_valid` is 1 exactly in the cycle after a strobe. Without a strobe, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eval_stb | input | 1 | Evaluate-now strobe |
| an_enable | input | 1 | Auto-negotiation enabled |
| loc_pause | input | 1 | Local advertised pause bit |
| loc_asym | input | 1 | Local advertised asymmetric-direction bit |
| lp_pause | input | 1 | Partner pause ability bit |
| lp_asym | input | 1 | Partner asymmetric-direction bit |
| req_mode | input | 3 | Requested mode (0..3, 4 default, 5..7 illegal) |
| full_duplex | input | 1 | Negotiated duplex is full |
| xon_cfg | input | 1 | XON frame sending configured |
| low_water | input | WATER_W | Configured low-water value |
| high_water | input | WATER_W | Configured high-water value |
| res_mode | output | 2 | Resolved mode |
| tx_fc_en | output | 1 | Transmit flow-control enable |
| rx_fc_en | output | 1 | Receive flow-control enable |
| lo_thresh | output | TH_W | Low threshold word with XON flag in top bit |
| hi_thresh | output | TH_W | High threshold word |
| res_valid | output | 1 | Result strobe, one cycle after `eval_stb` |
| cfg_err | output | 1 | Illegal requested mode seen at the last strobe |

## Verification
The assertions assume that every input is steady across the sampling edge. They also assume that the strobe is a plain level, with no condition on how close two strobes may come. Nothing is assumed about the request code, which is why the checker covers codes 5 to 7 explicitly.

The stimulus changes every input on the falling edge and holds the strobe for exactly one cycle. It walks all the pause-bit combinations that matter, with both duplex values and with legal and illegal requests. It also changes inputs without a strobe, to show that the result is held.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
    typedef enum logic [1:0] {
        FC_NONE = 2'd0,
        FC_RX   = 2'd1,
        FC_TX   = 2'd2,
        FC_FULL = 2'd3
    } fc_mode_e;

    localparam logic [2:0] REQ_DEFAULT = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_APPLIED,
        ST_HELD,
        ST_FAULT
    } rs_state_e;
endpackage

// File: rtl/pfc_table.sv
module pfc_table
    import pfc_pkg::*;
(
    input  logic       loc_pause,
    input  logic       loc_asym,
    input  logic       lp_pause,
    input  logic       lp_asym,
    input  logic [2:0] req_mode,
    input  logic       full_duplex,
    output fc_mode_e   mode,
    output logic       req_bad
);
    fc_mode_e raw_mode;
    logic     want_full;

    assign want_full = (req_mode == 3'(FC_FULL)) || (req_mode == REQ_DEFAULT);
    assign req_bad   = (req_mode > REQ_DEFAULT);

    // Capability table: symmetric first, then the two asymmetric cases.
    always_comb begin
        if (loc_pause && lp_pause)
            raw_mode = want_full ? FC_FULL : FC_RX;
        else if (!loc_pause && loc_asym && lp_pause && lp_asym)
            raw_mode = FC_TX;
        else if (loc_pause && loc_asym && !lp_pause && lp_asym)
            raw_mode = FC_RX;
        else
            raw_mode = FC_NONE;
    end

    // Half duplex overrides the table.
    assign mode = full_duplex ? raw_mode : FC_NONE;
endmodule

// File: rtl/pfc_thresh.sv
module pfc_thresh
    import pfc_pkg::*;
#(
    parameter int WATER_W = 16,
    parameter int TH_W    = 32
) (
    input  fc_mode_e           mode,
    input  logic               xon_cfg,
    input  logic [WATER_W-1:0] low_water,
    input  logic [WATER_W-1:0] high_water,
    output logic [TH_W-1:0]    lo_word,
    output logic [TH_W-1:0]    hi_word
);
    localparam int PAD_W = TH_W - 1 - WATER_W;

    logic tx_on;
    assign tx_on = mode[1];

    generate
        if (PAD_W > 0) begin : g_pad
            assign lo_word = tx_on ? {xon_cfg, {PAD_W{1'b0}}, low_water} : '0;
            assign hi_word = tx_on ? {{(PAD_W+1){1'b0}}, high_water} : '0;
        end else begin : g_nopad
            assign lo_word = tx_on ? {xon_cfg, low_water[TH_W-2:0]} : '0;
            assign hi_word = tx_on ? {1'b0, high_water[TH_W-2:0]} : '0;
        end
    endgenerate
endmodule

// File: rtl/pause_fc_resolver.sv
module pause_fc_resolver
    import pfc_pkg::*;
#(
    parameter int WATER_W = 16,
    parameter int TH_W    = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               eval_stb,
    input  logic               an_enable,
    input  logic               loc_pause,
    input  logic               loc_asym,
    input  logic               lp_pause,
    input  logic               lp_asym,
    input  logic [2:0]         req_mode,
    input  logic               full_duplex,
    input  logic               xon_cfg,
    input  logic [WATER_W-1:0] low_water,
    input  logic [WATER_W-1:0] high_water,
    output logic [1:0]         res_mode,
    output logic               tx_fc_en,
    output logic               rx_fc_en,
    output logic [TH_W-1:0]    lo_thresh,
    output logic [TH_W-1:0]    hi_thresh,
    output logic               res_valid,
    output logic               cfg_err
);
    rs_state_e       state, nxt;
    fc_mode_e        tbl_mode;
    logic            tbl_bad;
    logic [TH_W-1:0] lo_next, hi_next;

    pfc_table u_table (
        .loc_pause   (loc_pause),
        .loc_asym    (loc_asym),
        .lp_pause    (lp_pause),
        .lp_asym     (lp_asym),
        .req_mode    (req_mode),
        .full_duplex (full_duplex),
        .mode        (tbl_mode),
        .req_bad     (tbl_bad)
    );

    pfc_thresh #(.WATER_W(WATER_W), .TH_W(TH_W)) u_thresh (
        .mode       (tbl_mode),
        .xon_cfg    (xon_cfg),
        .low_water  (low_water),
        .high_water (high_water),
        .lo_word    (lo_next),
        .hi_word    (hi_next)
    );

    // Next-state logic: every state reacts to the strobe the same way.
    always_comb begin
        nxt = ST_IDLE;
        unique case (state)
            ST_IDLE, ST_APPLIED, ST_HELD, ST_FAULT: begin
                if (eval_stb) begin
                    if (!an_enable)   nxt = ST_HELD;
                    else if (tbl_bad) nxt = ST_FAULT;
                    else              nxt = ST_APPLIED;
                end
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Output registers, loaded only on the path into ST_APPLIED.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_mode  <= FC_NONE;
            tx_fc_en  <= 1'b0;
            rx_fc_en  <= 1'b0;
            lo_thresh <= '0;
            hi_thresh <= '0;
        end else if (nxt == ST_APPLIED) begin
            res_mode  <= tbl_mode;
            tx_fc_en  <= tbl_mode[1];
            rx_fc_en  <= tbl_mode[0];
            lo_thresh <= lo_next;
            hi_thresh <= hi_next;
        end
    end

    assign res_valid = (state != ST_IDLE);
    assign cfg_err   = (state == ST_FAULT);
endmodule

// File: rtl/pfc_checker.sv
module pfc_checker #(
    parameter int TH_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            eval_stb,
    input logic            an_enable,
    input logic [2:0]      req_mode,
    input logic            full_duplex,
    input logic [1:0]      res_mode,
    input logic            tx_fc_en,
    input logic            rx_fc_en,
    input logic [TH_W-1:0] lo_thresh,
    input logic [TH_W-1:0] hi_thresh,
    input logic            res_valid,
    input logic            cfg_err
);
    p_enable_map_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_fc_en == res_mode[1]) && (rx_fc_en == res_mode[0]));

    p_thresh_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_fc_en |-> (lo_thresh == '0) && (hi_thresh == '0));

    p_xon_needs_tx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lo_thresh[TH_W-1] |-> tx_fc_en);

    p_half_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_stb && an_enable && (req_mode <= 3'd4) && !full_duplex)
        |=> (res_mode == 2'd0));

    p_an_off_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_stb && !an_enable) |=> res_valid && !cfg_err &&
        $stable(res_mode) && $stable(lo_thresh) && $stable(hi_thresh));

    p_bad_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_stb && an_enable && (req_mode > 3'd4)) |=> cfg_err &&
        $stable(res_mode) && $stable(lo_thresh) && $stable(hi_thresh));

    p_valid_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        eval_stb |=> res_valid);

    p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_stb |=> !res_valid && !cfg_err && $stable(res_mode) &&
        $stable(lo_thresh) && $stable(hi_thresh));
endmodule

bind pause_fc_resolver pfc_checker #(.TH_W(TH_W)) u_pfc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .eval_stb    (eval_stb),
    .an_enable   (an_enable),
    .req_mode    (req_mode),
    .full_duplex (full_duplex),
    .res_mode    (res_mode),
    .tx_fc_en    (tx_fc_en),
    .rx_fc_en    (rx_fc_en),
    .lo_thresh   (lo_thresh),
    .hi_thresh   (hi_thresh),
    .res_valid   (res_valid),
    .cfg_err     (cfg_err)
);

// File: tb/pause_fc_resolver_tb.sv
module pause_fc_resolver_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATER_W    = 16;
    localparam int TH_W       = 32;
    localparam int NV         = 16;

    // Fields: [10]loc_pause [9]loc_asym [8]lp_pause [7]lp_asym
    //         [6:4]req [3]full_duplex [2]xon [1:0]expected mode
    localparam logic [10:0] VEC [NV] = '{
        11'b1_0_1_0_011_1_0_11,  // R2 symmetric, full requested
        11'b1_1_1_1_100_1_1_11,  // R2 default request counts as full
        11'b1_0_1_1_001_1_0_01,  // R2 symmetric, rx requested
        11'b1_1_1_0_000_1_0_01,  // R2 symmetric, none requested
        11'b1_0_1_0_010_1_1_01,  // R2 symmetric, tx requested
        11'b0_1_1_1_011_1_1_10,  // R3 with xon
        11'b0_1_1_1_000_1_0_10,  // R3 without xon
        11'b1_1_0_1_011_1_1_01,  // R4 rx only
        11'b0_0_1_1_011_1_0_00,  // R4 other -> none
        11'b0_1_1_0_011_1_0_00,  // R4 other -> none
        11'b0_1_0_1_011_1_0_00,  // R4 other -> none
        11'b1_0_0_1_011_1_0_00,  // R4 other -> none
        11'b1_1_0_0_011_1_0_00,  // R4 other -> none
        11'b1_0_1_0_011_0_1_00,  // R5 half duplex
        11'b0_1_1_1_011_0_1_00,  // R5 half duplex
        11'b1_1_0_1_011_0_0_00   // R5 half duplex
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               eval_stb = 1'b0;
    logic               an_enable = 1'b1;
    logic               loc_pause = 1'b0;
    logic               loc_asym = 1'b0;
    logic               lp_pause = 1'b0;
    logic               lp_asym = 1'b0;
    logic [2:0]         req_mode = 3'd0;
    logic               full_duplex = 1'b1;
    logic               xon_cfg = 1'b0;
    logic [WATER_W-1:0] low_water = '0;
    logic [WATER_W-1:0] high_water = '0;
    logic [1:0]         res_mode;
    logic               tx_fc_en, rx_fc_en, res_valid, cfg_err;
    logic [TH_W-1:0]    lo_thresh, hi_thresh;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pause_fc_resolver #(.WATER_W(WATER_W), .TH_W(TH_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .eval_stb(eval_stb), .an_enable(an_enable),
        .loc_pause(loc_pause), .loc_asym(loc_asym), .lp_pause(lp_pause),
        .lp_asym(lp_asym), .req_mode(req_mode), .full_duplex(full_duplex),
        .xon_cfg(xon_cfg), .low_water(low_water), .high_water(high_water),
        .res_mode(res_mode), .tx_fc_en(tx_fc_en), .rx_fc_en(rx_fc_en),
        .lo_thresh(lo_thresh), .hi_thresh(hi_thresh), .res_valid(res_valid),
        .cfg_err(cfg_err)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Expected outputs computed from the requirements.
    task automatic check_result(input string tag, input logic [1:0] m,
                                input logic xon, input logic [WATER_W-1:0] lw,
                                input logic [WATER_W-1:0] hw);
        logic [TH_W-1:0] lo_e, hi_e;
        lo_e = '0;
        hi_e = '0;
        if (m[1]) begin
            lo_e[WATER_W-1:0] = lw;
            lo_e[TH_W-1]      = xon;
            hi_e[WATER_W-1:0] = hw;
        end
        check(res_mode == m, {tag, " mode R2"}, 64'(res_mode), 64'(m));
        check({tx_fc_en, rx_fc_en} == m, {tag, " enables R6"},
              64'({tx_fc_en, rx_fc_en}), 64'(m));
        check(lo_thresh == lo_e, {tag, " low threshold R7 R8"},
              64'(lo_thresh), 64'(lo_e));
        check(hi_thresh == hi_e, {tag, " high threshold R7"},
              64'(hi_thresh), 64'(hi_e));
    endtask

    // Drive one strobe; returns at the falling edge after the sampling edge.
    task automatic strobe();
        eval_stb = 1'b1;
        @(negedge clk);
        eval_stb = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(res_mode == 2'd0 && !tx_fc_en && !rx_fc_en, "R1 mode/enables",
              64'({res_mode, tx_fc_en, rx_fc_en}), 64'd0);
        check(lo_thresh == '0 && hi_thresh == '0, "R1 thresholds",
              64'(lo_thresh | hi_thresh), 64'd0);
        check(!res_valid && !cfg_err, "R1 valid/err",
              64'({res_valid, cfg_err}), 64'd0);

        for (int i = 0; i < NV; i++) begin
            loc_pause   = VEC[i][10];
            loc_asym    = VEC[i][9];
            lp_pause    = VEC[i][8];
            lp_asym     = VEC[i][7];
            req_mode    = VEC[i][6:4];
            full_duplex = VEC[i][3];
            xon_cfg     = VEC[i][2];
            low_water   = WATER_W'(16'h0111 * (i + 1));
            high_water  = WATER_W'(16'hF000 - 16'h0101 * i);
            an_enable   = 1'b1;
            strobe();
            check(res_valid && !cfg_err, $sformatf("vec %0d valid R11", i),
                  64'({res_valid, cfg_err}), 64'b10);
            check_result($sformatf("vec %0d (R3 R4 R5)", i), VEC[i][1:0],
                         VEC[i][2], low_water, high_water);
        end

        // R11: valid lasts one cycle; no strobe means no change.
        loc_pause = 1'b1; loc_asym = 1'b0; lp_pause = 1'b1; lp_asym = 1'b0;
        req_mode = 3'd3; full_duplex = 1'b1; xon_cfg = 1'b1;
        low_water = 16'h00AA; high_water = 16'hBEEF;
        strobe();
        check_result("full setup R11", 2'd3, 1'b1, 16'h00AA, 16'hBEEF);
        @(negedge clk);
        check(!res_valid, "R11 valid drops", 64'(res_valid), 64'd0);
        loc_pause = 1'b0; full_duplex = 1'b0; low_water = 16'h1111;
        repeat (3) @(negedge clk);
        check(!res_valid, "R11 no strobe no valid", 64'(res_valid), 64'd0);
        check_result("no strobe hold R11", 2'd3, 1'b1, 16'h00AA, 16'hBEEF);

        // R9: autoneg disabled keeps result.
        an_enable = 1'b0;
        strobe();
        check(res_valid && !cfg_err, "R9 valid without error",
              64'({res_valid, cfg_err}), 64'b10);
        check_result("an off hold R9", 2'd3, 1'b1, 16'h00AA, 16'hBEEF);
        an_enable = 1'b1;
        req_mode  = 3'd7;  // R9 has priority over illegal request
        an_enable = 1'b0;
        strobe();
        check(!cfg_err, "R9 priority over illegal", 64'(cfg_err), 64'd0);

        // R10: illegal requests flag error, keep result.
        an_enable = 1'b1;
        for (int r = 5; r < 8; r++) begin
            req_mode = 3'(r);
            strobe();
            check(res_valid && cfg_err, $sformatf("R10 req %0d error", r),
                  64'({res_valid, cfg_err}), 64'b11);
            check_result($sformatf("R10 req %0d hold", r), 2'd3, 1'b1,
                         16'h00AA, 16'hBEEF);
        end
        @(negedge clk);
        check(!cfg_err, "R10 error clears", 64'(cfg_err), 64'd0);

        // R5 after hold: half duplex now applied on a legal strobe.
        req_mode = 3'd3;
        strobe();
        check(!cfg_err, "R10 legal after illegal", 64'(cfg_err), 64'd0);
        check_result("half duplex R5", 2'd0, 1'b0, 16'h0, 16'h0);

        // R8/R7: widest watermark values with xon off.
        loc_pause = 1'b0; loc_asym = 1'b1; lp_pause = 1'b1; lp_asym = 1'b1;
        full_duplex = 1'b1; xon_cfg = 1'b0;
        low_water = '1; high_water = '1;
        strobe();
        check_result("max water R7 R8", 2'd2, 1'b0, '1, '1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule